// File: doc/BRIEF.md
# Radio Frame Receive Assembler

This block receives packets from a byte-oriented radio transceiver that is controlled through 16-bit SPI commands. A separate SPI shifter carries each command. After a start request, the block switches the radio into receive mode and waits for the radio's active-low interrupt. Each falling edge of that interrupt means one byte is waiting in the radio. For each one, the block issues a status read and then a FIFO read, and it keeps the low byte of the FIFO reply as received data.

Bytes are placed in a local frame buffer in this order: group, header, payload length, payload, then two check bytes. When the configured group is nonzero, the block writes the group byte itself into slot 0, because the radio removes it as part of sync detection. A reflected CRC-16 runs over every byte of the frame, including the two check bytes, so an intact frame leaves a residue of zero. Reception ends when the declared length has been received, or when the buffer is full. The radio is then sent to idle, and the block presents the payload length, a CRC verdict and an address-match verdict. These stay valid until the next start request.

Top module: `rxFrameEngine`

## Requirements
- R1: A start request accepted while idle clears the fill count, the header and the length. It loads the CRC with 0xFFFF and folds the group byte into it when the group is nonzero. It then issues command 0x82DD. The ready flag drops on that request.
- R2: For each interrupt fall during reception, command 0x0000 is issued first and command 0xB000 second. Bits [7:0] of the second reply are the received byte. A command stays asserted with a stable word until `cmdDone`.
- R3: With a nonzero group, the group byte is stored at buffer index 0 before the first received byte. With group zero, the first received byte is stored at index 0.
- R4: Buffer index 1 holds the header, and index 2 holds the payload length, which is output on `frameLen`. The payload starts at index 3.
- R5: The CRC update is LSB first: XOR the byte into bits [7:0], then apply 8 right shifts, XORing 0xA001 after each shift that drops a 1. `crcOk` is 1 when the residue after the last stored byte is zero.
- R6: Reception ends when fill ≥ length+5 or fill ≥ 71. Command 0x820D is then issued, and `frameReady` rises one cycle after that command completes.
- R7: A length above 66 forces `crcOk` to 0.
- R8: `accept` is 1 in three cases: header bit 6 is 0, the node id equals 31, or header bits [4:0] equal the node id.
- R9: Interrupt falls while idle produce no command. After a frame, results hold until the next start request.
- R10: A new start request after a finished frame re-arms reception. The block then assembles another frame correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Begin a reception, accepted while idle |
| irqN | input | 1 | Radio interrupt, active low |
| nodeId | input | 5 | This node's address; 31 accepts all |
| groupId | input | 8 | Network group; 0 disables prepending |
| cmdValid | output | 1 | SPI command request |
| cmdWord | output | 16 | SPI command word |
| cmdDone | input | 1 | Command transfer finished, reply valid |
| rspWord | input | 16 | SPI reply word |
| rdAddr | input | 7 | Buffer read index |
| rdData | output | 8 | Buffer byte at rdAddr (combinational) |
| frameReady | output | 1 | Frame finished, results valid |
| frameLen | output | 8 | Received payload length |
| crcOk | output | 1 | CRC residue zero and length legal |
| accept | output | 1 | Frame addressed to this node |

## Verification
A command word appears on `cmdValid` in the cycle after the previous command's `cmdDone`. It can also appear two or three cycles after the byte store that follows an interrupt fall. For that reason, the bench waits for `cmdValid` at falling clock edges instead of counting a fixed delay, and then checks the word. `frameReady`, `crcOk` and `accept` are due one cycle after the idle command completes. The bench samples them one full clock later, at a falling edge. Buffer reads are combinational, so they are sampled a fraction of a cycle after `rdAddr` changes.

// File: rtl/rxPkg.sv
package rxPkg;

  localparam logic [15:0] CMD_RX_ON  = 16'h82DD;
  localparam logic [15:0] CMD_STATUS = 16'h0000;
  localparam logic [15:0] CMD_FIFO   = 16'hB000;
  localparam logic [15:0] CMD_IDLE   = 16'h820D;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY   = 16'hA001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_WAIT, ST_STAT, ST_READ, ST_PUT, ST_CHECK, ST_STOP
  } rxStateT;

  typedef struct packed {
    logic clear;
    logic capture;
    logic putGroup;
    logic putByte;
  } rxStrobeT;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxData.sv
module rxData
  import rxPkg::*;
#(
  parameter int BUF_DEPTH = 71,
  parameter int ADDR_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobeT          strobe,
  input  logic [7:0]        groupId,
  input  logic [7:0]        rspByte,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [7:0]        lenR,
  output logic [7:0]        hdrR,
  output logic [15:0]       crcR,
  output logic              fillZero,
  output logic              frameFull
);

  localparam int FILL_W = $clog2(BUF_DEPTH + 1);

  logic [7:0]        bufMem [BUF_DEPTH];
  logic [FILL_W-1:0] fill;
  logic [7:0]        rxByte;
  logic [ADDR_W-1:0] wrIdx;

  assign wrIdx    = fill[ADDR_W-1:0];
  assign fillZero = (fill == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fill   <= '0;
      lenR   <= '0;
      hdrR   <= '0;
      crcR   <= CRC_SEED;
      rxByte <= '0;
      for (int i = 0; i < BUF_DEPTH; i++) bufMem[i] <= '0;
    end else begin
      if (strobe.clear) begin
        fill <= '0;
        lenR <= '0;
        hdrR <= '0;
        crcR <= (groupId != 8'h00) ? crcStep(CRC_SEED, groupId) : CRC_SEED;
      end
      if (strobe.capture) rxByte <= rspByte;
      if (strobe.putGroup && int'(fill) < BUF_DEPTH) begin
        bufMem[wrIdx] <= groupId;
        fill          <= fill + 1'b1;
      end
      if (strobe.putByte && int'(fill) < BUF_DEPTH) begin
        bufMem[wrIdx] <= rxByte;
        fill          <= fill + 1'b1;
        crcR          <= crcStep(crcR, rxByte);
        if (fill == FILL_W'(1)) hdrR <= rxByte;
        if (fill == FILL_W'(2)) lenR <= rxByte;
      end
    end
  end

  assign frameFull = (int'(fill) >= int'(lenR) + 5) || (int'(fill) >= BUF_DEPTH);
  assign rdData    = (int'(rdAddr) < BUF_DEPTH) ? bufMem[rdAddr] : 8'h00;

  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(fill) <= BUF_DEPTH);

  assert_group_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.putGroup |=> (bufMem[0] == $past(groupId)) && (fill == FILL_W'(1)));

  assert_crc_seed_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clear && groupId == 8'h00) |=> (crcR == CRC_SEED) && (fill == '0));

endmodule

// File: rtl/rxCtrl.sv
module rxCtrl
  import rxPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        irqN,
  input  logic        cmdDone,
  input  logic        fillZero,
  input  logic        groupNz,
  input  logic        frameFull,
  output logic        cmdValid,
  output logic [15:0] cmdWord,
  output rxStrobeT    strobe,
  output logic        frameReady
);

  rxStateT state, nxt;
  logic    irqPrev;
  logic    irqFall;
  logic    pend;

  assign irqFall = irqPrev & ~irqN;

  always_comb begin
    nxt      = state;
    strobe   = '0;
    cmdValid = 1'b0;
    cmdWord  = 16'h0000;
    case (state)
      ST_IDLE: if (startReq) begin
        strobe.clear = 1'b1;
        nxt          = ST_ARM;
      end
      ST_ARM: begin
        cmdValid = 1'b1;
        cmdWord  = CMD_RX_ON;
        if (cmdDone) nxt = ST_WAIT;
      end
      ST_WAIT: if (pend || irqFall) nxt = ST_STAT;
      ST_STAT: begin
        cmdValid = 1'b1;
        cmdWord  = CMD_STATUS;
        if (cmdDone) nxt = ST_READ;
      end
      ST_READ: begin
        cmdValid = 1'b1;
        cmdWord  = CMD_FIFO;
        if (cmdDone) begin
          strobe.capture = 1'b1;
          nxt            = ST_PUT;
        end
      end
      ST_PUT: begin
        if (fillZero && groupNz) begin
          strobe.putGroup = 1'b1;
        end else begin
          strobe.putByte = 1'b1;
          nxt            = ST_CHECK;
        end
      end
      ST_CHECK: nxt = frameFull ? ST_STOP : ST_WAIT;
      ST_STOP: begin
        cmdValid = 1'b1;
        cmdWord  = CMD_IDLE;
        if (cmdDone) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      irqPrev    <= 1'b1;
      pend       <= 1'b0;
      frameReady <= 1'b0;
    end else begin
      state   <= nxt;
      irqPrev <= irqN;
      if (state == ST_IDLE || state == ST_STOP || state == ST_WAIT) pend <= 1'b0;
      else if (irqFall) pend <= 1'b1;
      if (state == ST_IDLE && startReq) frameReady <= 1'b0;
      else if (state == ST_STOP && cmdDone) frameReady <= 1'b1;
    end
  end

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdDone) |=> cmdValid && $stable(cmdWord));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !startReq) |=> !cmdValid);

  assert_read_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdWord == CMD_FIFO && !$past(cmdValid && cmdWord == CMD_FIFO))
      |-> ($past(cmdWord) == CMD_STATUS) && $past(cmdDone));

endmodule

// File: rtl/rxFrameEngine.sv
module rxFrameEngine
  import rxPkg::*;
#(
  parameter int BUF_DEPTH   = 71,
  parameter int MAX_PAYLOAD = 66,
  parameter int ADDR_W      = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              irqN,
  input  logic [4:0]        nodeId,
  input  logic [7:0]        groupId,
  output logic              cmdValid,
  output logic [15:0]       cmdWord,
  input  logic              cmdDone,
  input  logic [15:0]       rspWord,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              frameReady,
  output logic [7:0]        frameLen,
  output logic              crcOk,
  output logic              accept
);

  localparam logic [4:0] ANY_NODE = 5'd31;

  rxStrobeT    strobe;
  logic [7:0]  lenR, hdrR;
  logic [15:0] crcR;
  logic        fillZero, frameFull;
  logic        unusedRspHi;

  assign unusedRspHi = ^rspWord[15:8];

  rxCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .irqN       (irqN),
    .cmdDone    (cmdDone),
    .fillZero   (fillZero),
    .groupNz    (groupId != 8'h00),
    .frameFull  (frameFull),
    .cmdValid   (cmdValid),
    .cmdWord    (cmdWord),
    .strobe     (strobe),
    .frameReady (frameReady)
  );

  rxData #(.BUF_DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .groupId   (groupId),
    .rspByte   (rspWord[7:0]),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .lenR      (lenR),
    .hdrR      (hdrR),
    .crcR      (crcR),
    .fillZero  (fillZero),
    .frameFull (frameFull)
  );

  logic lenLegal, addrHit;
  assign lenLegal   = (int'(lenR) <= MAX_PAYLOAD);
  assign addrHit    = !hdrR[6] || (nodeId == ANY_NODE) || (hdrR[4:0] == nodeId);
  assign frameLen   = lenR;
  assign crcOk      = frameReady && lenLegal && (crcR == 16'h0000);
  assign accept     = frameReady && addrHit;

  assert_len_veto_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameReady && int'(frameLen) > MAX_PAYLOAD) |-> !crcOk);

  assert_stop_then_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameReady) |-> $past(cmdDone) && ($past(cmdWord) == CMD_IDLE));

  assert_ready_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frameReady && !startReq) |=> frameReady && $stable(frameLen));

endmodule

// File: tb/sim_rxFrameEngine.sv
module sim_rxFrameEngine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        irqN = 1'b1;
  logic [4:0]  nodeId = 5'd5;
  logic [7:0]  groupId = 8'hD4;
  logic        cmdValid;
  logic [15:0] cmdWord;
  logic        cmdDone = 1'b0;
  logic [15:0] rspWord = 16'h0000;
  logic [6:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        frameReady, crcOk, accept;
  logic [7:0]  frameLen;

  int total = 0;
  int bad = 0;

  logic [7:0] fr [0:127];
  int nTot;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxFrameEngine u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .irqN(irqN),
    .nodeId(nodeId), .groupId(groupId), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .cmdDone(cmdDone), .rspWord(rspWord), .rdAddr(rdAddr), .rdData(rdData),
    .frameReady(frameReady), .frameLen(frameLen), .crcOk(crcOk), .accept(accept)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[0] ^ b[k];
      r = r >> 1;
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  task automatic serve(input logic [15:0] expWord, input logic [7:0] b, input string req);
    int w = 0;
    while (!cmdValid && w < 100) begin @(negedge clk); w++; end
    chk(req, {15'd0, cmdValid, cmdWord}, {15'd0, 1'b1, expWord});
    cmdDone = 1'b1;
    rspWord = {8'hA5, b};
    @(negedge clk);
    cmdDone = 1'b0;
  endtask

  task automatic startRx;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    chk("R10 ready cleared by start", {31'd0, frameReady}, 32'd0);
    serve(16'h82DD, 8'h00, "R1 receiver-on command");
  endtask

  task automatic feedByte(input logic [7:0] b);
    @(negedge clk); irqN = 1'b0;
    @(negedge clk); irqN = 1'b1;
    serve(16'h0000, 8'h00, "R2 status read first");
    serve(16'hB000, b, "R2 fifo read second");
  endtask

  task automatic buildFrame(input logic [7:0] g, input logic [7:0] hdr, input int len,
                            input logic [7:0] seed, input bit corrupt);
    logic [15:0] c = 16'hFFFF;
    fr[0] = g; fr[1] = hdr; fr[2] = 8'(len);
    for (int i = 0; i < len && i < 120; i++) fr[3+i] = 8'(seed + 8'(i * 7));
    for (int i = 0; i < len + 3 && i < 125; i++) c = refCrc(c, fr[i]);
    if (len + 4 < 128) begin fr[len+3] = c[7:0]; fr[len+4] = c[15:8]; end
    if (corrupt) fr[3] = fr[3] ^ 8'h10;
    nTot = (len + 5 < 71) ? len + 5 : 71;
  endtask

  task automatic runFrame(input string tag, input int expLen, input bit expCrc, input bit expAcc);
    int first = (groupId != 8'h00) ? 1 : 0;
    bit same = 1'b1;
    startRx();
    for (int i = first; i < nTot; i++) feedByte(fr[i]);
    serve(16'h820D, 8'h00, "R6 idle command at end");
    @(negedge clk);
    chk({"R6 frameReady ", tag}, {31'd0, frameReady}, 32'd1);
    chk({"R4 frameLen ", tag}, {24'd0, frameLen}, expLen);
    chk({"R5 crcOk ", tag}, {31'd0, crcOk}, {31'd0, expCrc});
    chk({"R8 accept ", tag}, {31'd0, accept}, {31'd0, expAcc});
    for (int i = 0; i < nTot; i++) begin
      rdAddr = 7'(i);
      #1;
      if (rdData !== fr[i]) begin
        same = 1'b0;
        $display("  mismatch at index %0d: %0h vs %0h", i, rdData, fr[i]);
      end
    end
    chk({"R3 buffer contents ", tag}, {31'd0, same}, 32'd1);
  endtask

  task automatic testReset;
    chk("R9 reset cmdValid", {31'd0, cmdValid}, 32'd0);
    chk("R9 reset frameReady", {31'd0, frameReady}, 32'd0);
    chk("R5 reset crcOk", {31'd0, crcOk}, 32'd0);
    chk("R8 reset accept", {31'd0, accept}, 32'd0);
  endtask

  task automatic testBroadcast;
    buildFrame(8'hD4, 8'h03, 4, 8'h11, 1'b0);
    runFrame("broadcast", 4, 1'b1, 1'b1);
  endtask

  task automatic testAddressed;
    buildFrame(8'hD4, 8'h45, 2, 8'h20, 1'b0);
    runFrame("match", 2, 1'b1, 1'b1);
    buildFrame(8'hD4, 8'h47, 3, 8'h30, 1'b0);
    runFrame("mismatch", 3, 1'b1, 1'b0);
    nodeId = 5'd31;
    buildFrame(8'hD4, 8'h47, 3, 8'h30, 1'b0);
    runFrame("promiscuous", 3, 1'b1, 1'b1);
    nodeId = 5'd5;
  endtask

  task automatic testCorrupt;
    buildFrame(8'hD4, 8'h01, 5, 8'h40, 1'b1);
    runFrame("corrupt R5", 5, 1'b0, 1'b1);
  endtask

  task automatic testOversize;
    buildFrame(8'hD4, 8'h02, 70, 8'h05, 1'b0);
    runFrame("oversize R7", 70, 1'b0, 1'b1);
  endtask

  task automatic testNoGroup;
    groupId = 8'h00;
    buildFrame(8'h33, 8'h08, 3, 8'h77, 1'b0);
    runFrame("group zero R3", 3, 1'b1, 1'b1);
    groupId = 8'hD4;
  endtask

  task automatic testEmpty;
    buildFrame(8'hD4, 8'h04, 0, 8'h00, 1'b0);
    runFrame("zero length", 0, 1'b1, 1'b1);
  endtask

  task automatic testIdleIrq;
    bit quiet = 1'b1;
    @(negedge clk); irqN = 1'b0;
    @(negedge clk); irqN = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cmdValid) quiet = 1'b0;
    end
    chk("R9 no command while idle", {31'd0, quiet}, 32'd1);
    chk("R9 ready held while idle", {31'd0, frameReady}, 32'd1);
    buildFrame(8'hD4, 8'h06, 1, 8'h99, 1'b0);
    runFrame("rearm R10", 1, 1'b1, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testBroadcast();
    testAddressed();
    testCorrupt();
    testOversize();
    testNoGroup();
    testEmpty();
    testIdleIrq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule